// File: doc/BRIEF.md
# Bit Test-and-Set Execution Unit

This unit executes the bit-test-and-set operation for register destinations. The front end hands it an already split descriptor: the mode flag, the wide-operand prefix bit, the 16-bit override prefix, the bus-lock prefix, the opcode byte that follows the 0F escape, the ModRM reg and mod fields, and the immediate byte. It also receives the destination register value and the low bits of the offset register. From these the unit picks an operand width and an offset source. It copies the addressed bit into the carry flag and returns the destination with that bit forced to one.

Alongside the result the unit emits a per-flag write mask, a writeback enable and an invalid-opcode fault. Requests enter through a valid/ready pair. One cycle later the result leaves through a registered valid/ready pair, and it is held there while the consumer stalls. Memory-destination descriptors belong to another unit. They pass through here with no side effects.

Top module: `btset_exec`

## Requirements
- R1: Opcode byte 0xAB with mod = 3 takes the bit offset from `off_lo`.
- R2: Opcode byte 0xBA with ModRM reg = 5 and mod = 3 takes the bit offset from `imm8`.
- R3: The operand width is 64 when `long_mode` and `pfx_rexw` are both 1. Otherwise it is 16 when `pfx_opsize` is 1, and 32 when it is not. Outside long mode `pfx_rexw` has no effect.
- R4: The offset is reduced modulo the operand width. Only its low 4, 5 or 6 bits are used for 16, 32 or 64 bits.
- R5: `res_cf` is the value of the addressed bit before the operation, and the addressed bit of `res_val` is 1. At width 16, bits 63:16 of `res_val` equal the destination and bits 15:0 equal it except at the addressed bit. At width 32, bits 63:32 are zero. At width 64, all bits other than the addressed one are unchanged.
- R6: A successful operation gives `wb_en` = 1, `fault_ud` = 0 and `flag_wmask` = 6'b000001. The mask bit order is CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5, so ZF and the undefined flags are never written.
- R7: With `pfx_lock` = 1 and mod = 3 on a matching opcode, `fault_ud` = 1, `wb_en` = 0, `flag_wmask` = 0, `res_cf` = 0 and `res_val` equals the destination.
- R8: A descriptor matching neither form (another opcode byte, or 0xBA with reg ≠ 5) gives the same fault outputs as R7, at any mod.
- R9: A matching descriptor with mod ≠ 3 gives `wb_en` = 0, `fault_ud` = 0, `flag_wmask` = 0, `res_cf` = 0 and `res_val` equal to the destination, even when locked.
- R10: A request accepted on a clock edge (`in_valid` and `in_ready`) appears with `out_valid` = 1 after that edge. While `out_valid` is 1 and `out_ready` is 0, the outputs hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R11: During and after reset, and before any request, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| long_mode | input | 1 | Core is in 64-bit mode |
| pfx_rexw | input | 1 | Wide-operand prefix bit |
| pfx_opsize | input | 1 | 16-bit operand override prefix present |
| pfx_lock | input | 1 | Bus-lock prefix present |
| opc_byte | input | 8 | Opcode byte after the 0F escape |
| modrm_reg | input | 3 | ModRM reg field |
| modrm_mod | input | 2 | ModRM mod field |
| imm8 | input | 8 | Immediate byte |
| dst_val | input | 64 | Current destination register value |
| off_lo | input | 6 | Low bits of the offset register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_val | output | 64 | Value to write back |
| res_cf | output | 1 | New carry flag |
| flag_wmask | output | 6 | Per-flag write enable |
| wb_en | output | 1 | Register writeback enable |
| fault_ud | output | 1 | Invalid-opcode fault |

## Verification
Register-offset and immediate-offset requests are sent at all three widths. Destinations hold the addressed bit both clear and set, which separates the old-bit capture from the set. Offsets beyond the width, such as 37 at 32 bits, 70-style immediates at 64 bits and 0xFF at 16 bits, expose a missing modulo reduction. Dirty upper destination bits tell preservation at 16 bits apart from zeroing at 32 bits. Wide-prefix and override combinations in and out of long mode separate the width precedence. A long mixed stream under a randomly stalling consumer separates correct holding and back-pressure from dropped or duplicated results.

// File: rtl/btset_pkg.sv
package btset_pkg;

   typedef enum logic [1:0] {
      OSZ_16 = 2'd0,
      OSZ_32 = 2'd1,
      OSZ_64 = 2'd2
   } opsize_e;

   typedef enum logic [1:0] {
      ACT_EXEC  = 2'd0,
      ACT_FAULT = 2'd1,
      ACT_PASS  = 2'd2
   } action_e;

   localparam int NFLAGS  = 6;
   localparam int FLAG_CF = 0;
   localparam int FLAG_PF = 1;
   localparam int FLAG_AF = 2;
   localparam int FLAG_ZF = 3;
   localparam int FLAG_SF = 4;
   localparam int FLAG_OF = 5;

   typedef struct packed {
      action_e act;
      opsize_e osz;
      logic    use_imm;
   } dec_t;

endpackage

// File: rtl/btset_decode.sv
module btset_decode
   import btset_pkg::*;
#(
   parameter logic [7:0] OPC_REG   = 8'hAB,
   parameter logic [7:0] OPC_IMM   = 8'hBA,
   parameter logic [2:0] IMM_EXT   = 3'd5,
   parameter bit         SUPPORT_64 = 1'b1
) (
   input  logic       long_mode,
   input  logic       rexw,
   input  logic       opsize_ovr,
   input  logic       lock,
   input  logic [7:0] opc,
   input  logic [2:0] reg_f,
   input  logic [1:0] mod_f,
   output dec_t       dec
);

   localparam logic [1:0] MOD_REG = 2'd3;

   logic wide;
   logic hit_reg;
   logic hit_imm;
   logic reg_dst;

   generate
      if (SUPPORT_64) begin : g_w64
         assign wide = long_mode & rexw;
      end else begin : g_w32
         assign wide = 1'b0;
      end
   endgenerate

   assign hit_reg = (opc == OPC_REG);
   assign hit_imm = (opc == OPC_IMM) && (reg_f == IMM_EXT);
   assign reg_dst = (mod_f == MOD_REG);

   always_comb begin
      dec.use_imm = hit_imm;
      if (wide)            dec.osz = OSZ_64;
      else if (opsize_ovr) dec.osz = OSZ_16;
      else                 dec.osz = OSZ_32;

      if (!(hit_reg || hit_imm)) dec.act = ACT_FAULT;
      else if (!reg_dst)         dec.act = ACT_PASS;
      else if (lock)             dec.act = ACT_FAULT;
      else                       dec.act = ACT_EXEC;
   end

endmodule

// File: rtl/btset_datapath.sv
module btset_datapath
   import btset_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [IDX_W-1:0]  off_lo,
   input  logic [7:0]        imm,
   input  dec_t              dec,
   output logic [DATA_W-1:0] res,
   output logic              cf
);

   localparam int OFF_W = (IDX_W > 8) ? IDX_W : 8;
   localparam int HALF  = 16;
   localparam int WORD  = 32;
   localparam logic [OFF_W-1:0] MASK16 = OFF_W'(HALF - 1);
   localparam logic [OFF_W-1:0] MASK32 = OFF_W'(WORD - 1);
   localparam logic [OFF_W-1:0] MASK64 = OFF_W'(DATA_W - 1);

   logic [OFF_W-1:0]  off_pick;
   logic [OFF_W-1:0]  off_mask;
   logic [OFF_W-1:0]  off_mod;
   logic [DATA_W-1:0] sel_oh;
   logic [DATA_W-1:0] set_val;

   assign off_pick = dec.use_imm ? OFF_W'(imm) : OFF_W'(off_lo);

   always_comb begin
      unique case (dec.osz)
         OSZ_16:  off_mask = MASK16;
         OSZ_32:  off_mask = MASK32;
         default: off_mask = MASK64;
      endcase
   end

   assign off_mod = off_pick & off_mask;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_sel
         assign sel_oh[i] = (off_mod == OFF_W'(i));
      end
   endgenerate

   assign cf      = |(dst & sel_oh);
   assign set_val = dst | sel_oh;

   always_comb begin
      unique case (dec.osz)
         OSZ_16:  res = {dst[DATA_W-1:HALF], set_val[HALF-1:0]};
         OSZ_32:  res = {{(DATA_W-WORD){1'b0}}, set_val[WORD-1:0]};
         default: res = set_val;
      endcase
   end

endmodule

// File: rtl/btset_outreg.sv
module btset_outreg
   import btset_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] nxt_val,
   input  logic              nxt_cf,
   input  logic [NFLAGS-1:0] nxt_mask,
   input  logic              nxt_wb,
   input  logic              nxt_fault,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] res_val,
   output logic              res_cf,
   output logic [NFLAGS-1:0] flag_wmask,
   output logic              wb_en,
   output logic              fault_ud
);

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (in_ready) begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_val    <= '0;
         res_cf     <= 1'b0;
         flag_wmask <= '0;
         wb_en      <= 1'b0;
         fault_ud   <= 1'b0;
      end else if (take) begin
         res_val    <= nxt_val;
         res_cf     <= nxt_cf;
         flag_wmask <= nxt_mask;
         wb_en      <= nxt_wb;
         fault_ud   <= nxt_fault;
      end
   end

endmodule

// File: rtl/btset_exec.sv
module btset_exec
   import btset_pkg::*;
#(
   parameter int         DATA_W     = 64,
   parameter int         IDX_W      = $clog2(DATA_W),
   parameter logic [7:0] OPC_REG    = 8'hAB,
   parameter logic [7:0] OPC_IMM    = 8'hBA,
   parameter logic [2:0] IMM_EXT    = 3'd5,
   parameter bit         SUPPORT_64 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              long_mode,
   input  logic              pfx_rexw,
   input  logic              pfx_opsize,
   input  logic              pfx_lock,
   input  logic [7:0]        opc_byte,
   input  logic [2:0]        modrm_reg,
   input  logic [1:0]        modrm_mod,
   input  logic [7:0]        imm8,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [IDX_W-1:0]  off_lo,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] res_val,
   output logic              res_cf,
   output logic [NFLAGS-1:0] flag_wmask,
   output logic              wb_en,
   output logic              fault_ud
);

   localparam logic [NFLAGS-1:0] CF_ONLY = NFLAGS'(1) << FLAG_CF;

   generate
      if (DATA_W != 64) begin : g_bad_width
         $error("btset_exec: DATA_W must be 64");
      end
      if (IDX_W != $clog2(DATA_W)) begin : g_bad_idx
         $error("btset_exec: IDX_W must equal clog2(DATA_W)");
      end
      if (OPC_REG == OPC_IMM) begin : g_bad_opc
         $error("btset_exec: opcode forms must differ");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] dp_res;
   logic              dp_cf;
   logic [DATA_W-1:0] nxt_val;
   logic              nxt_cf;
   logic [NFLAGS-1:0] nxt_mask;
   logic              nxt_wb;
   logic              nxt_fault;

   btset_decode #(
      .OPC_REG    (OPC_REG),
      .OPC_IMM    (OPC_IMM),
      .IMM_EXT    (IMM_EXT),
      .SUPPORT_64 (SUPPORT_64)
   ) u_dec (
      .long_mode  (long_mode),
      .rexw       (pfx_rexw),
      .opsize_ovr (pfx_opsize),
      .lock       (pfx_lock),
      .opc        (opc_byte),
      .reg_f      (modrm_reg),
      .mod_f      (modrm_mod),
      .dec        (dec)
   );

   btset_datapath #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_dp (
      .dst    (dst_val),
      .off_lo (off_lo),
      .imm    (imm8),
      .dec    (dec),
      .res    (dp_res),
      .cf     (dp_cf)
   );

   always_comb begin
      nxt_val   = dst_val;
      nxt_cf    = 1'b0;
      nxt_mask  = '0;
      nxt_wb    = 1'b0;
      nxt_fault = 1'b0;
      unique case (dec.act)
         ACT_EXEC: begin
            nxt_val  = dp_res;
            nxt_cf   = dp_cf;
            nxt_mask = CF_ONLY;
            nxt_wb   = 1'b1;
         end
         ACT_FAULT: nxt_fault = 1'b1;
         default: ;
      endcase
   end

   btset_outreg #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .nxt_val    (nxt_val),
      .nxt_cf     (nxt_cf),
      .nxt_mask   (nxt_mask),
      .nxt_wb     (nxt_wb),
      .nxt_fault  (nxt_fault),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .res_val    (res_val),
      .res_cf     (res_cf),
      .flag_wmask (flag_wmask),
      .wb_en      (wb_en),
      .fault_ud   (fault_ud)
   );

endmodule

// File: rtl/btset_exec_chk.sv
module btset_exec_chk
   import btset_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] res_val,
   input logic              res_cf,
   input logic [NFLAGS-1:0] flag_wmask,
   input logic              wb_en,
   input logic              fault_ud
);

   // R10: an accepted request shows up on the output side after the edge
   a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R10: a stalled result stays put
   a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(res_val)
                                     && $stable(res_cf) && $stable(wb_en)
                                     && $stable(fault_ud)));

   // R10: back-pressure reaches the input side
   a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R7 / R8: a fault writes nothing
   a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && fault_ud) |-> (!wb_en && flag_wmask == '0 && !res_cf));

   // R6: a writeback only ever touches the carry flag
   a_r6_cf_only: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wb_en) |-> (flag_wmask == NFLAGS'(1) && !fault_ud));

endmodule

bind btset_exec btset_exec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .res_val    (res_val),
   .res_cf     (res_cf),
   .flag_wmask (flag_wmask),
   .wb_en      (wb_en),
   .fault_ud   (fault_ud)
);

// File: tb/btset_exec_test.sv
`timescale 1ns/1ps
module btset_exec_test;

   typedef struct {
      logic [63:0] res;
      logic        cf;
      logic [5:0]  mask;
      logic        wb;
      logic        flt;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        long_mode = 1'b0;
   logic        pfx_rexw = 1'b0;
   logic        pfx_opsize = 1'b0;
   logic        pfx_lock = 1'b0;
   logic [7:0]  opc_byte = 8'h00;
   logic [2:0]  modrm_reg = 3'd0;
   logic [1:0]  modrm_mod = 2'd3;
   logic [7:0]  imm8 = 8'h00;
   logic [63:0] dst_val = 64'd0;
   logic [5:0]  off_lo = 6'd0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] res_val;
   logic        res_cf;
   logic [5:0]  flag_wmask;
   logic        wb_en;
   logic        fault_ud;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t q[$];
   bit   stall_mode = 1'b0;
   logic [31:0] rdy_lfsr = 32'h1234_5678;
   logic [63:0] dat_lfsr = 64'hACE1_2468_9BDF_1357;

   always #4 clk = ~clk;

   btset_exec uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .long_mode(long_mode), .pfx_rexw(pfx_rexw), .pfx_opsize(pfx_opsize),
      .pfx_lock(pfx_lock), .opc_byte(opc_byte), .modrm_reg(modrm_reg),
      .modrm_mod(modrm_mod), .imm8(imm8), .dst_val(dst_val), .off_lo(off_lo),
      .out_valid(out_valid), .out_ready(out_ready), .res_val(res_val),
      .res_cf(res_cf), .flag_wmask(flag_wmask), .wb_en(wb_en), .fault_ud(fault_ud)
   );

   function automatic exp_t model(input logic lm, input logic w, input logic o16,
                                  input logic lk, input logic [7:0] opc,
                                  input logic [2:0] rg, input logic [1:0] md,
                                  input logic [7:0] im, input logic [63:0] d,
                                  input logic [5:0] of, input string tag);
      exp_t e;
      int   size;
      int   pos;
      logic [63:0] s;
      e.tag = tag; e.res = d; e.cf = 1'b0; e.mask = 6'd0; e.wb = 1'b0; e.flt = 1'b0;
      if (!(opc == 8'hAB || (opc == 8'hBA && rg == 3'd5))) begin
         e.flt = 1'b1;                       // R8
      end else if (md != 2'd3) begin
         ;                                   // R9
      end else if (lk) begin
         e.flt = 1'b1;                       // R7
      end else begin
         size = (lm && w) ? 64 : (o16 ? 16 : 32);          // R3
         pos  = ((opc == 8'hAB) ? int'(of) : int'(im)) % size; // R1 R2 R4
         e.cf = d[pos];
         s    = d | (64'd1 << pos);
         if (size == 16)      e.res = {d[63:16], s[15:0]};
         else if (size == 32) e.res = {32'd0, s[31:0]};
         else                 e.res = s;
         e.mask = 6'b000001; e.wb = 1'b1;    // R6
      end
      return e;
   endfunction

   task automatic send(input logic lm, input logic w, input logic o16, input logic lk,
                       input logic [7:0] opc, input logic [2:0] rg, input logic [1:0] md,
                       input logic [7:0] im, input logic [63:0] d, input logic [5:0] of,
                       input string tag);
      exp_t e;
      e = model(lm, w, o16, lk, opc, rg, md, im, d, of, tag);
      @(negedge clk);
      long_mode = lm; pfx_rexw = w; pfx_opsize = o16; pfx_lock = lk;
      opc_byte = opc; modrm_reg = rg; modrm_mod = md; imm8 = im;
      dst_val = d; off_lo = of; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      q.push_back(e);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   // consumer ready pattern, changed away from both edges
   always @(posedge clk) begin
      #2;
      rdy_lfsr  = {rdy_lfsr[30:0], rdy_lfsr[31] ^ rdy_lfsr[21] ^ rdy_lfsr[1] ^ rdy_lfsr[0]};
      out_ready = stall_mode ? rdy_lfsr[3] : 1'b1;
   end

   // monitor / scoreboard
   logic        was_stall = 1'b0;
   logic [63:0] stall_val;
   logic        stall_cf;
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (was_stall) begin
            n_chk++;
            if (!out_valid || res_val !== stall_val || res_cf !== stall_cf) begin
               n_bad++;
               $display("FAIL R10 hold: valid=%b val=%h cf=%b expected valid=1 val=%h cf=%b",
                        out_valid, res_val, res_cf, stall_val, stall_cf);
            end
         end
         was_stall = 1'b0;
         if (out_valid) begin
            if (out_ready) begin
               n_chk++;
               if (q.size() == 0) begin
                  n_bad++;
                  $display("FAIL R10 unexpected result: val=%h expected none", res_val);
               end else begin
                  e = q.pop_front();
                  if (res_val !== e.res || res_cf !== e.cf || flag_wmask !== e.mask
                      || wb_en !== e.wb || fault_ud !== e.flt) begin
                     n_bad++;
                     $display("FAIL %s: val=%h cf=%b mask=%b wb=%b flt=%b expected val=%h cf=%b mask=%b wb=%b flt=%b",
                              e.tag, res_val, res_cf, flag_wmask, wb_en, fault_ud,
                              e.res, e.cf, e.mask, e.wb, e.flt);
                  end
               end
            end else begin
               n_chk++;
               if (in_ready !== 1'b0) begin
                  n_bad++;
                  $display("FAIL R10 backpressure: in_ready=%b expected 0", in_ready);
               end
               was_stall = 1'b1; stall_val = res_val; stall_cf = res_cf;
            end
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;   // R11 during reset
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R11 in reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      n_chk++;   // R11 after reset, idle
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R11 after reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
      end

      // R1 register offset, 32-bit
      send(1, 0, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h0,                 6'd5,  "R1 reg clear bit");
      send(1, 0, 0, 0, 8'hAB, 3'd2, 2'd3, 8'h00, 64'h0000_0000_0000_0020, 6'd5, "R1 reg set bit");
      // R2 immediate offset
      send(1, 0, 0, 0, 8'hBA, 3'd5, 2'd3, 8'd9,  64'h0,                 6'd0,  "R2 imm form");
      send(0, 0, 0, 0, 8'hBA, 3'd5, 2'd3, 8'd31, 64'h8000_0000,         6'd3,  "R2 imm top bit");
      // R3 widths
      send(1, 1, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h0,                 6'd63, "R3 wide 64");
      send(1, 1, 1, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h0,                 6'd40, "R3 wide beats override");
      send(0, 1, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'hFFFF_0000_0000_0000, 6'd40, "R3 wide ignored legacy");
      send(1, 0, 1, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h0,                 6'd3,  "R3 override 16");
      // R4 modulo
      send(1, 0, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h0,                 6'd37, "R4 reg mod 32");
      send(1, 1, 0, 0, 8'hBA, 3'd5, 2'd3, 8'd70, 64'h0,                 6'd0,  "R4 imm mod 64");
      send(1, 0, 1, 0, 8'hBA, 3'd5, 2'd3, 8'hFF, 64'h0,                 6'd0,  "R4 imm mod 16");
      send(0, 0, 0, 0, 8'hBA, 3'd5, 2'd3, 8'hE3, 64'h0,                 6'd0,  "R4 imm mod 32");
      // R5 upper bits
      send(1, 0, 1, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'hDEAD_BEEF_CAFE_0001, 6'd4, "R5 16 keeps upper");
      send(1, 0, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'hDEAD_BEEF_0000_0010, 6'd4, "R5 32 zeroes upper");
      send(1, 1, 0, 0, 8'hAB, 3'd0, 2'd3, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 6'd17, "R5 64 all ones");
      // R6 mask on a plain success
      send(0, 0, 0, 0, 8'hAB, 3'd7, 2'd3, 8'h00, 64'h1234,              6'd0,  "R6 mask cf only");
      // R7 lock on register destination
      send(1, 0, 0, 1, 8'hAB, 3'd0, 2'd3, 8'h00, 64'h55,                6'd1,  "R7 lock reg form");
      send(1, 1, 0, 1, 8'hBA, 3'd5, 2'd3, 8'd2,  64'h0,                 6'd0,  "R7 lock imm form");
      // R8 decode misses
      send(1, 0, 0, 0, 8'hBA, 3'd4, 2'd3, 8'd2,  64'h0,                 6'd0,  "R8 imm wrong ext");
      send(1, 0, 0, 0, 8'hA3, 3'd0, 2'd3, 8'd0,  64'h7,                 6'd1,  "R8 other opcode");
      // R9 memory destination
      send(1, 0, 0, 1, 8'hAB, 3'd0, 2'd0, 8'd0,  64'h99,                6'd2,  "R9 memory locked");
      send(0, 0, 0, 0, 8'hBA, 3'd5, 2'd2, 8'd3,  64'h1,                 6'd0,  "R9 memory imm");

      // R10 mixed stream under a stalling consumer
      stall_mode = 1'b1;
      for (int k = 0; k < 300; k++) begin
         logic [7:0] opc;
         dat_lfsr = {dat_lfsr[62:0], dat_lfsr[63] ^ dat_lfsr[62] ^ dat_lfsr[60] ^ dat_lfsr[59]};
         opc = (k % 7 == 6) ? 8'hA3 : (dat_lfsr[0] ? 8'hAB : 8'hBA);
         send(dat_lfsr[1], dat_lfsr[2], dat_lfsr[3], (k % 11 == 0),
              opc, (dat_lfsr[4] ? 3'd5 : dat_lfsr[7:5]), ((k % 13 == 0) ? 2'd1 : 2'd3),
              dat_lfsr[15:8], dat_lfsr ^ {dat_lfsr[31:0], dat_lfsr[63:32]},
              dat_lfsr[21:16], "R10 stream");
      end
      stall_mode = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule